// File: doc/BRIEF.md
# SPI Receiver with Zero-Run Resynchronization

This block receives SPI data as a slave in mode 0. It takes the most significant bit first, builds 8-bit bytes and raises a one-cycle strobe for each completed byte. The serial clock, data and select lines are sampled into the system clock domain. The block finds clock edges by comparing successive samples, so the SPI clock must run well below the system clock.

A slave that has lost its bit alignment can recover without a power cycle. Normal traffic never holds ten zero bytes in a row, so a long run of zero bytes counts as a request to realign. The master sends at least twelve zero bytes and then leaves the clock line still for a pause. The slave counts consecutive zero bytes. Once the count reaches its threshold, it times how long the clock line stays quiet. When the pause has lasted long enough, the slave clears its bit position and partial shift contents, pulses a completion flag and waits for a fresh byte. The master can start a resync this way even when the slave is misaligned, because a misaligned slave still sees enough whole zero bytes.

Top module: `spi_zr_slave`

## Requirements
- R1: After reset, rx_valid and resync_done are low and rx_byte is 0x00.
- R2: With cs_n low, MOSI is taken on each rising SCLK edge, most significant bit first. After every eighth such edge, rx_byte holds the assembled byte and rx_valid is high for exactly one system clock cycle.
- R3: When cs_n goes high with fewer than eight bits taken, those bits are discarded and no strobe is produced. The next byte starts at bit 7 after cs_n is low again.
- R4: SCLK edges that arrive while cs_n is high produce no byte.
- R5: Once ZERO_RUN_MIN (default 10) consecutive 0x00 bytes have been received, GAP_CYCLES system clock cycles without any SCLK edge produce a single resync_done pulse that lasts one cycle.
- R6: A run shorter than ZERO_RUN_MIN zero bytes followed by a quiet gap produces no resync_done.
- R7: Any byte other than 0x00 sets the zero-run count back to zero.
- R8: An SCLK edge of either polarity during the gap measurement restarts the gap timer and leaves the zero-run count as it was.
- R9: A resync clears the bit position and shift contents, so the next eight rising SCLK edges form one complete byte whatever bits were pending before.
- R10: After resync_done, the zero-run count and gap timer are zero, so a further quiet period without new zero bytes gives no second pulse.
- R11: The zero-run count saturates at its maximum value instead of wrapping, so an arbitrarily long zero run still leads to exactly one resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | SPI serial clock from the master (idle low) |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Slave select, active low |
| rx_byte | output | 8 | Most recently completed byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| resync_done | output | 1 | One-cycle pulse when a resynchronization completes |

## Verification
Random byte streams with a random SCLK rate show that ordinary traffic is assembled correctly and never causes a resync. Directed zero runs of 9, 10 and 20 bytes, and a run of 9 broken by a nonzero byte, separate the threshold, the clearing of the count and saturation. A single SCLK pulse inside the pause separates a timer that restarts from one that keeps counting. A stream shifted by three stray bits shows that a resync really restores byte alignment, and a byte cut short by cs_n shows that partial bits are dropped.

// File: rtl/spi_zr_pkg.sv
// Shared definitions for the zero-run resynchronizing SPI receiver.
// Assumes 8-bit frames; every module takes the frame width from here.
package spi_zr_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_zr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each input is stable for several clk cycles; it adds no glitch
// filtering. RST_VAL gives the inactive level of each line after reset.
module spi_zr_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the sampled inputs one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_async;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_zr_shifter.sv
// Assembles bytes MSB first from synchronized SPI samples.
// Assumes 'sample' is a one-cycle rising SCLK indication aligned with
// bit_in. A deselect or a clear request drops any partial byte.
module spi_zr_shifter
    import spi_zr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample,
    input  logic  bit_in,
    input  logic  deselect,
    input  logic  clear,
    output byte_t byte_out,
    output logic  byte_valid
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic [BIT_CNT_W-1:0] bit_pos;
    byte_t                shreg;

    // Purpose: track bit position, shift data and publish completed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pos    <= '0;
            shreg      <= '0;
            byte_out   <= '0;
            byte_valid <= 1'b0;
        end else if (deselect || clear) begin
            bit_pos    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
        end else if (sample) begin
            shreg <= {shreg[BYTE_W-2:0], bit_in};
            if (bit_pos == LAST_BIT) begin
                bit_pos    <= '0;
                byte_out   <= {shreg[BYTE_W-2:0], bit_in};
                byte_valid <= 1'b1;
            end else begin
                bit_pos    <= bit_pos + 1'b1;
                byte_valid <= 1'b0;
            end
        end else begin
            byte_valid <= 1'b0;
        end
    end

    // R2: a strobe only follows a sampling edge.
    assert_valid_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(sample));

    // R2: the strobe lasts a single cycle.
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R3/R4: no byte is published while deselected.
    assert_no_byte_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        deselect |=> !byte_valid);

    // R9: a clear request returns the bit position to the first bit.
    assert_clear_realigns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bit_pos == '0));
endmodule

// File: rtl/spi_zr_gap_detect.sv
// Counts consecutive zero bytes and, once the run reaches ZERO_RUN_MIN,
// times a quiet SCLK period. A full GAP_CYCLES without an edge raises a
// one-cycle resync pulse. Assumes byte_valid is a one-cycle strobe and
// sclk_edge marks either SCLK polarity in the system clock domain.
module spi_zr_gap_detect
    import spi_zr_pkg::*;
#(
    parameter int ZERO_RUN_MIN = 10,
    parameter int GAP_CYCLES = 10_000_000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  byte_valid,
    input  byte_t byte_data,
    input  logic  sclk_edge,
    output logic  resync_pulse
);
    localparam int ZW = $clog2(ZERO_RUN_MIN + 1);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [ZW-1:0] ZMAX = '1;
    localparam logic [ZW-1:0] ZMIN = ZW'(ZERO_RUN_MIN);
    localparam logic [GW-1:0] GLAST = GW'(GAP_CYCLES - 1);

    logic [ZW-1:0] zero_run;
    logic [GW-1:0] gap_cnt;
    logic          armed;
    logic          gap_hit;

    assign armed   = (zero_run >= ZMIN);
    assign gap_hit = armed && !sclk_edge && (gap_cnt == GLAST);

    // Purpose: count consecutive zero bytes with saturation; clear on resync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_run <= '0;
        end else if (gap_hit) begin
            zero_run <= '0;
        end else if (byte_valid) begin
            if (byte_data != '0) begin
                zero_run <= '0;
            end else if (zero_run != ZMAX) begin
                zero_run <= zero_run + 1'b1;
            end
        end
    end

    // Purpose: time the quiet SCLK period while armed; any edge restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (!armed || sclk_edge || gap_hit) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Purpose: register the one-cycle resync indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resync_pulse <= 1'b0;
        end else begin
            resync_pulse <= gap_hit;
        end
    end

    // R5: the completion flag is a single-cycle pulse.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |=> !resync_pulse);

    // R6: a resync needs a run of at least the threshold.
    assert_done_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |-> ($past(zero_run) >= ZMIN));

    // R7: a nonzero byte ends the run.
    assert_nonzero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_data != '0) |=> (zero_run == '0));

    // R8: an edge while armed restarts the timer but keeps the run.
    assert_edge_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sclk_edge && !byte_valid) |=> (gap_cnt == '0 && $stable(zero_run)));

    // R10: both counters are zero when the pulse appears.
    assert_clear_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |-> (zero_run == '0 && gap_cnt == '0));

    // R11: the run count holds at its maximum instead of wrapping.
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_run == ZMAX && byte_valid && byte_data == '0) |=> (zero_run == ZMAX));
endmodule

// File: rtl/spi_zr_slave.sv
// SPI mode 0 slave receiver with in-band realignment: a run of zero bytes
// followed by a quiet SCLK gap clears the bit alignment. Assumes SCLK runs
// slowly enough that each level lasts at least two clk cycles after the
// synchronizers.
module spi_zr_slave
    import spi_zr_pkg::*;
#(
    parameter int ZERO_RUN_MIN = 10,
    parameter int GAP_CYCLES = 10_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       cs_n,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       resync_done
);
    localparam int NLINES = 3;
    localparam logic [NLINES-1:0] LINE_IDLE = 3'b100;

    logic [NLINES-1:0] lines_sync;
    logic sclk_s, mosi_s, csn_s;
    logic sclk_prev;
    logic sclk_rise, sclk_edge;
    byte_t byte_w;
    logic  valid_w;
    logic  resync_w;

    spi_zr_sync #(
        .W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({cs_n, mosi, sclk}),
        .q_sync(lines_sync)
    );

    assign sclk_s = lines_sync[0];
    assign mosi_s = lines_sync[1];
    assign csn_s  = lines_sync[2];

    // Purpose: keep the previous synchronized SCLK level for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_prev && !csn_s;
    assign sclk_edge = sclk_s ^ sclk_prev;

    spi_zr_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sample(sclk_rise), .bit_in(mosi_s),
        .deselect(csn_s), .clear(resync_w),
        .byte_out(byte_w), .byte_valid(valid_w)
    );

    spi_zr_gap_detect #(
        .ZERO_RUN_MIN(ZERO_RUN_MIN), .GAP_CYCLES(GAP_CYCLES)
    ) u_gap (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(valid_w), .byte_data(byte_w),
        .sclk_edge(sclk_edge), .resync_pulse(resync_w)
    );

    assign rx_byte     = byte_w;
    assign rx_valid    = valid_w;
    assign resync_done = resync_w;

    // R5: resync and a byte strobe never coincide, since the gap is quiet.
    assert_done_not_with_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(resync_done && rx_valid));
endmodule

// File: tb/tb_spi_zr_slave.sv
module tb_spi_zr_slave;
    localparam int GAP = 200;
    localparam int ZMIN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic cs_n = 1'b1;
    logic [7:0] rx_byte;
    logic rx_valid;
    logic resync_done;

    int n_checks = 0;
    int n_errors = 0;
    int n_got = 0;
    int n_done = 0;
    logic [7:0] got [512];
    logic [7:0] sent [64];

    always #2.5 clk = ~clk;

    spi_zr_slave #(.ZERO_RUN_MIN(ZMIN), .GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .resync_done(resync_done)
    );

    // Record strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            got[n_got % 512] = rx_byte;
            n_got++;
        end
        if (rst_n && resync_done) n_done++;
    end

    function automatic bit expect_resync(input int run, input int quiet);
        return (run >= ZMIN) && (quiet >= GAP);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int half);
        mosi = b;
        wait_clk(half);
        sclk = 1'b1;
        wait_clk(half);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int half);
        for (int i = 7; i >= 0; i--) send_bit(b[i], half);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_byte(8'h00, 3);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int g0, d0, run;
        void'($urandom(32'd2024));
        wait_clk(5);
        // R1: reset state
        check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        check(resync_done == 1'b0, "R1 resync_done", int'(resync_done), 0);
        check(rx_byte == 8'h00, "R1 rx_byte", int'(rx_byte), 0);
        rst_n = 1'b1;
        wait_clk(5);
        cs_n = 1'b0;
        wait_clk(5);

        // R2: directed bytes
        g0 = n_got;
        send_byte(8'hA5, 3);
        send_byte(8'h81, 2);
        wait_clk(10);
        check(n_got == g0 + 2, "R2 count", n_got - g0, 2);
        check(got[g0 % 512] == 8'hA5, "R2 byte0", int'(got[g0 % 512]), 8'hA5);
        check(got[(g0 + 1) % 512] == 8'h81, "R2 byte1", int'(got[(g0 + 1) % 512]), 8'h81);

        // R2: random stream at random SCLK rate, no resync expected
        g0 = n_got;
        d0 = n_done;
        run = 0;
        for (int i = 0; i < 40; i++) begin
            sent[i] = 8'($urandom);
            if (sent[i] == 8'h00) run++; else run = 0;
            if (run >= ZMIN) begin sent[i] = 8'h5A; run = 0; end
            send_byte(sent[i], $urandom_range(5, 2));
        end
        wait_clk(10);
        check(n_got == g0 + 40, "R2 random count", n_got - g0, 40);
        for (int i = 0; i < 40; i++)
            check(got[(g0 + i) % 512] == sent[i], "R2 random byte",
                  int'(got[(g0 + i) % 512]), int'(sent[i]));
        check(n_done == d0, "R7 random no resync", n_done - d0, 0);

        // R3: partial byte dropped on deselect
        g0 = n_got;
        for (int i = 0; i < 5; i++) send_bit(1'b1, 3);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(6);
        // R4: edges while deselected produce nothing
        send_byte(8'hFF, 3);
        wait_clk(6);
        check(n_got == g0, "R4 no byte while deselected", n_got - g0, 0);
        cs_n = 1'b0;
        wait_clk(6);
        send_byte(8'h3C, 3);
        wait_clk(10);
        check(n_got == g0 + 1, "R3 count", n_got - g0, 1);
        check(got[g0 % 512] == 8'h3C, "R3 realigned byte", int'(got[g0 % 512]), 8'h3C);

        // R6: nine zeros then a gap
        d0 = n_done;
        send_zeros(ZMIN - 1);
        wait_clk(GAP + 40);
        check(n_done - d0 == int'(expect_resync(ZMIN - 1, GAP + 40)), "R6 short run",
              n_done - d0, 0);
        send_byte(8'h55, 3);

        // R7: run broken by a nonzero byte
        d0 = n_done;
        send_zeros(ZMIN - 1);
        send_byte(8'h01, 3);
        send_zeros(ZMIN - 1);
        wait_clk(GAP + 40);
        check(n_done == d0, "R7 broken run", n_done - d0, 0);
        send_byte(8'h55, 3);

        // R5: threshold run then a gap
        d0 = n_done;
        send_zeros(ZMIN);
        wait_clk(GAP + 40);
        check(n_done - d0 == int'(expect_resync(ZMIN, GAP + 40)), "R5 threshold run",
              n_done - d0, 1);
        // R10: a second gap gives no further pulse
        wait_clk(GAP + 40);
        check(n_done == d0 + 1, "R10 no second pulse", n_done - d0, 1);

        // R8: edge inside gap restarts the timer, run is kept
        d0 = n_done;
        send_zeros(ZMIN);
        wait_clk(GAP / 2);
        cs_n = 1'b1;
        wait_clk(2);
        sclk = 1'b1;
        wait_clk(3);
        sclk = 1'b0;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(GAP * 7 / 10);
        check(n_done == d0, "R8 timer restarted", n_done - d0, 0);
        wait_clk(GAP / 2);
        check(n_done == d0 + 1, "R8 run kept", n_done - d0, 1);

        // R11: long run saturates, exactly one resync
        d0 = n_done;
        send_zeros(20);
        wait_clk(GAP + 40);
        check(n_done == d0 + 1, "R11 long run single pulse", n_done - d0, 1);
        wait_clk(GAP + 40);
        check(n_done == d0 + 1, "R11 no wrap pulse", n_done - d0, 1);

        // R9: misaligned by three stray bits, resync restores alignment
        g0 = n_got;
        d0 = n_done;
        for (int i = 0; i < 3; i++) send_bit(1'b1, 3);
        send_zeros(12);
        wait_clk(GAP + 40);
        check(n_done == d0 + 1, "R9 misaligned resync", n_done - d0, 1);
        check(n_got == g0 + 12, "R9 misaligned count", n_got - g0, 12);
        check(got[g0 % 512] == 8'hE0, "R9 misaligned first", int'(got[g0 % 512]), 8'hE0);
        send_byte(8'hA5, 3);
        wait_clk(10);
        check(n_got == g0 + 13, "R9 count after resync", n_got - g0, 13);
        check(got[(g0 + 12) % 512] == 8'hA5, "R9 aligned byte",
              int'(got[(g0 + 12) % 512]), 8'hA5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule